// File: doc/BRIEF.md
# Strobed-Address Dynamic Memory Emulator

This block behaves like a one-bit-wide dynamic memory whose row and column addresses share one narrow address bus. All pin activity is sampled on a fast system clock. A high-to-low transition of the row strobe captures the row half of the address. A high-to-low transition of the column strobe, taken while the row strobe is low, captures the column half and starts the access. With the default width of 5 address pins the array holds 32 x 32 cells. Setting `AW` to 8 gives the full 256 x 256 (64K x 1) organisation.

The write-enable level at the column fall selects the cycle type: a read, or an early write. A write-enable fall later in a read cycle turns it into a read-modify-write. The data output is enabled by the column strobe alone. Read data therefore stays on the pin for as long as the column strobe stays low, even while the row strobe toggles to perform hidden refresh. `q_oe` marks when the emulated pin drives; the pad turns it into a three-state output.

Every row-strobe fall refreshes a group of rows. The group is selected by the low `AW-1` row bits (7 bits, so 128 groups, at full size). Each group carries an age counter. A group left unrefreshed for `WINDOW` clocks raises a sticky decay flag.

Top module: `dram_emu`

## Requirements
- R1: While `rst_n` is low and after its release, `q_oe` and `decay_err` read 0.
- R2: A read captures the row at the sampled fall of `ras_n` and the column at the sampled fall of `cas_n`, with `ras_n` low and `we_n` high. From the clock after the column fall, `q_oe` is 1 and `q` equals the stored bit at {row, column}.
- R3: When `we_n` is low at the column fall (early write), `din` is stored at {row, column}, and `q_oe` stays 0 in the following cycle.
- R4: A fall of `we_n` during an open read, with `cas_n` and `ras_n` still low, stores `din` into the cell just read. `q` keeps the old read value until `cas_n` rises.
- R5: In page mode, `ras_n` stays low and every further `cas_n` fall accesses a new column in the same row. Reads and early writes may be mixed freely.
- R6: After any clock edge at which `cas_n` is sampled high, `q_oe` is 0 in the next cycle. A refresh cycle that uses only the row strobe never enables the output.
- R7: With `cas_n` held low after a read, `ras_n` may rise and fall again to refresh another row, and `q_oe` and `q` remain unchanged.
- R8: Every sampled `ras_n` fall resets the age of refresh group `addr[AW-2:0]`. This applies to refresh-only, read, write and hidden cycles alike, so rows r and r + 2^(AW-1) share one group.
- R9: When any group's age reaches `WINDOW` clocks since its last refresh (or since reset), `decay_err` becomes 1 and stays 1 until reset.
- R10: Refresh cycles and decay detection leave stored cell contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low; also gates the output |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Shared row/column address bus |
| din | input | 1 | Write data bit |
| q | output | 1 | Read data bit, meaningful while `q_oe` is 1 |
| q_oe | output | 1 | Output drive enable of the data pin |
| decay_err | output | 1 | Sticky flag: some refresh group exceeded `WINDOW` clocks |

## Verification
The hardest situation to reach from the ports is proving that a hidden refresh really restarts a group's age. Its only visible effect is the absence of a decay error thousands of clocks later. The stimulus first refreshes all groups, then waits half a window. It then refreshes every group except one with refresh-only cycles, and reaches the last group through the row strobe toggling under a held read that uses the upper-half row alias. Finally it waits until the first sweep is older than the window and checks that `decay_err` is still clear, before letting all groups expire to check the sticky flag.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

    // Access event decoded from the strobes in one sampling cycle
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_READ   = 2'd1,
        EV_EWRITE = 2'd2,
        EV_RMW    = 2'd3
    } dram_ev_e;

endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_row,
    input  logic [AW-1:0] wr_col,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_row,
    input  logic [AW-1:0] rd_col,
    output logic          rd_bit
);

    localparam int ROWS = 1 << AW;
    localparam int COLS = 1 << AW;

    logic [COLS-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_row][wr_col] <= wr_bit;
        end
    end

    assign rd_bit = cells[rd_row][rd_col];

endmodule

// File: rtl/dram_age_tracker.sv
module dram_age_tracker #(
    parameter int GW     = 4,
    parameter int WINDOW = 3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_en,
    input  logic [GW-1:0] ref_grp,
    output logic          any_expired
);

    localparam int             GROUPS = 1 << GW;
    localparam int             CW     = $clog2(WINDOW + 1);
    localparam logic [CW-1:0]  LIMIT  = CW'(WINDOW);

    logic [GROUPS-1:0] expired;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [CW-1:0] age_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q <= '0;
            end else if (ref_en && (ref_grp == GW'(g))) begin
                age_q <= '0;
            end else if (age_q != LIMIT) begin
                age_q <= age_q + CW'(1);
            end
        end

        assign expired[g] = (age_q == LIMIT);
    end

    assign any_expired = |expired;

endmodule

// File: rtl/dram_emu.sv
module dram_emu
    import dram_emu_pkg::*;
#(
    parameter int AW     = 5,
    parameter int WINDOW = 3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          q,
    output logic          q_oe,
    output logic          decay_err
);

    localparam int RFW = AW - 1;

    typedef struct packed {
        logic          ras_p;
        logic          cas_p;
        logic          we_p;
        logic [AW-1:0] row;
        logic [AW-1:0] wr_row;
        logic [AW-1:0] wr_col;
        logic          oe;
        logic          dq;
        logic          err;
    } state_t;

    state_t s_q, s_d;

    logic          ras_fall, cas_fall, we_fall;
    logic [AW-1:0] row_sel;
    dram_ev_e      ev;
    logic          wr_en;
    logic [AW-1:0] wr_r, wr_c;
    logic          rd_bit;
    logic          any_expired;

    // Strobe edges and access decode
    always_comb begin
        ras_fall = s_q.ras_p & ~ras_n;
        cas_fall = s_q.cas_p & ~cas_n & ~ras_n;
        we_fall  = s_q.we_p & ~we_n;
        row_sel  = ras_fall ? addr : s_q.row;
        ev       = EV_NONE;
        if (cas_fall) begin
            ev = we_n ? EV_READ : EV_EWRITE;
        end else if (s_q.oe && !cas_n && !ras_n && we_fall) begin
            ev = EV_RMW;
        end
        wr_en = (ev == EV_EWRITE) || (ev == EV_RMW);
        wr_r  = (ev == EV_RMW) ? s_q.wr_row : row_sel;
        wr_c  = (ev == EV_RMW) ? s_q.wr_col : addr;
    end

    // Next state
    always_comb begin
        s_d       = s_q;
        s_d.ras_p = ras_n;
        s_d.cas_p = cas_n;
        s_d.we_p  = we_n;
        if (ras_fall) begin
            s_d.row = addr;
        end
        case (ev)
            EV_READ: begin
                s_d.oe     = 1'b1;
                s_d.dq     = rd_bit;
                s_d.wr_row = row_sel;
                s_d.wr_col = addr;
            end
            EV_EWRITE: begin
                s_d.oe = 1'b0;
            end
            default: begin
            end
        endcase
        if (cas_n) begin
            s_d.oe = 1'b0;
        end
        if (any_expired) begin
            s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ras_p  <= 1'b1;
            s_q.cas_p  <= 1'b1;
            s_q.we_p   <= 1'b1;
            s_q.row    <= '0;
            s_q.wr_row <= '0;
            s_q.wr_col <= '0;
            s_q.oe     <= 1'b0;
            s_q.dq     <= 1'b0;
            s_q.err    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    dram_cell_array #(.AW(AW)) u_cells (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_row (wr_r),
        .wr_col (wr_c),
        .wr_bit (din),
        .rd_row (row_sel),
        .rd_col (addr),
        .rd_bit (rd_bit)
    );

    dram_age_tracker #(.GW(RFW), .WINDOW(WINDOW)) u_age (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_en      (ras_fall),
        .ref_grp     (addr[RFW-1:0]),
        .any_expired (any_expired)
    );

    assign q         = s_q.dq;
    assign q_oe      = s_q.oe;
    assign decay_err = s_q.err;

endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic q,
    input logic q_oe,
    input logic decay_err
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!q_oe && !decay_err));

    // R6
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |=> !q_oe);

    // R2
    read_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && $past(cas_n) && we_n) |=> q_oe);

    // R3
    early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && $past(cas_n) && !we_n) |=> !q_oe);

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_oe && !cas_n) |=> (q_oe && $stable(q)));

    // R9
    sticky_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decay_err |=> decay_err);

endmodule

bind dram_emu dram_emu_chk u_chk (.*);

// File: tb/sim_dram_emu.sv
module sim_dram_emu;

    localparam int AW  = 5;
    localparam int W   = 3000;
    localparam int NC  = 1 << AW;
    localparam int NG  = 1 << (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic          q, q_oe, decay_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dram_emu #(.AW(AW), .WINDOW(W)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .q(q), .q_oe(q_oe), .decay_err(decay_err)
    );

    // Behavioural reference model
    bit m_rasp, m_casp, m_wep, m_oe, m_dq, m_dqk, m_err;
    int m_row, m_wrr, m_wrc;
    bit mem [NC*NC];
    bit memk [NC*NC];
    int age [NG];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rasp = 1; m_casp = 1; m_wep = 1;
            m_oe = 0; m_dq = 0; m_dqk = 0; m_err = 0; m_row = 0;
            m_wrr = 0; m_wrc = 0;
            for (int g = 0; g < NG; g++) age[g] = 0;
        end else begin
            bit rf, cf, wf, rmw, expd;
            int rs, a;
            a    = int'(addr);
            rf   = m_rasp && !ras_n;
            cf   = m_casp && !cas_n && !ras_n;
            wf   = m_wep && !we_n;
            rmw  = !cf && m_oe && !cas_n && !ras_n && wf;
            rs   = rf ? a : m_row;
            expd = 0;
            for (int g = 0; g < NG; g++) if (age[g] == W) expd = 1;
            if (cf) begin
                if (we_n) begin
                    m_oe = 1; m_dq = mem[rs*NC + a]; m_dqk = memk[rs*NC + a];
                    m_wrr = rs; m_wrc = a;
                end else begin
                    mem[rs*NC + a] = din; memk[rs*NC + a] = 1; m_oe = 0;
                end
            end else if (rmw) begin
                mem[m_wrr*NC + m_wrc] = din; memk[m_wrr*NC + m_wrc] = 1;
            end
            if (cas_n) m_oe = 0;
            if (expd) m_err = 1;
            for (int g = 0; g < NG; g++) begin
                if (rf && (a % NG) == g) age[g] = 0;
                else if (age[g] < W) age[g] = age[g] + 1;
            end
            if (rf) m_row = a;
            m_rasp = ras_n; m_casp = cas_n; m_wep = we_n;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 oe vs model", q_oe, m_oe);
            if (m_oe && m_dqk) chk("R2 data vs model", q, m_dq);
            chk("R9 decay vs model", decay_err, m_err);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ras_down(input int r);
        addr = AW'(r); ras_n = 1'b0; tick(1);
    endtask

    task automatic do_write(input int r, input int c, input logic d);
        ras_down(r);
        addr = AW'(c); din = d; we_n = 1'b0; cas_n = 1'b0; tick(1);
        chk("R3 early write keeps output off", q_oe, 1'b0);
        cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; tick(1);
    endtask

    task automatic do_read(input int r, input int c, input logic e, input string req);
        ras_down(r);
        addr = AW'(c); we_n = 1'b1; cas_n = 1'b0; tick(1);
        chk(req, q_oe, 1'b1);
        chk(req, q, e);
        tick(1);
        chk("R2 data held while CAS low", q, e);
        cas_n = 1'b1; ras_n = 1'b1; tick(1);
        chk("R6 output off after CAS high", q_oe, 1'b0);
    endtask

    task automatic do_rmw(input int r, input int c, input logic old, input logic d);
        ras_down(r);
        addr = AW'(c); cas_n = 1'b0; tick(1);
        chk("R4 read part", q, old);
        we_n = 1'b0; din = d; tick(1);
        chk("R4 old data held", q, old);
        chk("R4 output stays on", q_oe, 1'b1);
        tick(1);
        cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; tick(1);
    endtask

    task automatic ras_only(input int r);
        addr = AW'(r); ras_n = 1'b0; tick(1);
        chk("R6 refresh-only never drives", q_oe, 1'b0);
        tick(1); ras_n = 1'b1; tick(1);
    endtask

    task automatic hidden(input int r, input int c, input logic e, input int refrow);
        ras_down(r);
        addr = AW'(c); we_n = 1'b1; cas_n = 1'b0; tick(1);
        chk("R2 hidden read", q, e);
        ras_n = 1'b1; tick(1);
        addr = AW'(refrow); ras_n = 1'b0; tick(1);
        chk("R7 oe kept in hidden refresh", q_oe, 1'b1);
        chk("R7 data kept in hidden refresh", q, e);
        tick(1); ras_n = 1'b1; tick(1);
        chk("R7 data kept after RAS rise", q, e);
        cas_n = 1'b1; tick(1);
        chk("R6 off after hidden cycle", q_oe, 1'b0);
    endtask

    task automatic sweep(input int skip);
        for (int g = 0; g < NG; g++) if (g != skip) ras_only(g);
    endtask

    task automatic page_test();
        ras_down(9);
        we_n = 1'b0;
        addr = AW'(0);  din = 1'b1; cas_n = 1'b0; tick(1); cas_n = 1'b1; tick(1);
        addr = AW'(1);  din = 1'b0; cas_n = 1'b0; tick(1); cas_n = 1'b1; tick(1);
        addr = AW'(31); din = 1'b1; cas_n = 1'b0; tick(1); cas_n = 1'b1; tick(1);
        we_n = 1'b1;
        addr = AW'(31); cas_n = 1'b0; tick(1);
        chk("R5 page read col 31", q, 1'b1); cas_n = 1'b1; tick(1);
        addr = AW'(0);  cas_n = 1'b0; tick(1);
        chk("R5 page read col 0", q, 1'b1); cas_n = 1'b1; tick(1);
        addr = AW'(1);  cas_n = 1'b0; tick(1);
        chk("R5 page read col 1", q, 1'b0);
        chk("R5 page output on", q_oe, 1'b1);
        cas_n = 1'b1; ras_n = 1'b1; tick(1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1; tick(1);
        chk("R1 reset oe", q_oe, 1'b0);
        chk("R1 reset decay", decay_err, 1'b0);

        do_write(3, 7, 1'b1);
        do_write(3, 8, 1'b0);
        do_write(19, 7, 1'b0);
        do_write(4, 7, 1'b1);
        do_read(3, 7, 1'b1, "R2 read row3 col7");
        do_read(3, 8, 1'b0, "R2 read row3 col8");
        do_read(19, 7, 1'b0, "R2 read row19 col7");
        do_read(4, 7, 1'b1, "R2 read row4 col7");
        do_rmw(3, 8, 1'b0, 1'b1);
        do_read(3, 8, 1'b1, "R4 value written by rmw");
        page_test();
        ras_only(9);
        do_read(9, 31, 1'b1, "R10 data kept after refresh");
        hidden(4, 7, 1'b1, 12);

        sweep(-1);
        chk("R9 no decay after sweep", decay_err, 1'b0);
        tick(1500);
        sweep(5);
        hidden(3, 7, 1'b1, 21);
        tick(1600);
        chk("R8 hidden refresh of alias row 21 kept group 5 alive", decay_err, 1'b0);
        tick(3100);
        chk("R9 decay raised", decay_err, 1'b1);
        sweep(-1);
        tick(3);
        chk("R9 decay sticky", decay_err, 1'b1);
        do_read(3, 7, 1'b1, "R10 data kept after decay");

        done = 1;
        rst_n = 1'b0; tick(1);
        chk("R1 oe in reset", q_oe, 1'b0);
        chk("R1 decay cleared", decay_err, 1'b0);
        rst_n = 1'b1; tick(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule